// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This block performs an 8-bit or 16-bit add, subtract or bitwise logic operation on two operands. It returns the result combinationally and keeps six status flags in a register: sign, zero, auxiliary carry, parity, carry and overflow. A processor datapath uses it as the flag-producing ALU slice. The caller chooses the operation, the operand width and whether the flag register takes the new values this cycle.

Carry and auxiliary carry are reported as a borrow for subtractions. Parity always looks at the low byte of the result, even when the operation is a word operation. The with-carry operations fold an incoming carry or borrow bit into the arithmetic. The plain operations ignore that bit.

Top module: `status_flag_unit`

## Requirements
- R1: `op_sel` selects the operation: 0 add, 1 add with carry, 2 subtract (opa minus opb), 3 subtract with borrow, 4 AND, 5 OR, 6 XOR, 7 pass opa. `result` is combinational. When `word_mode` is 0, only bits 7:0 of the operands are used and `result[15:8]` is 0.
- R2: After an update, `flag_sign` equals the result MSB: bit 15 in word mode, bit 7 in byte mode.
- R3: After an update, `flag_zero` is 1 exactly when the full result is zero.
- R4: After an update, `flag_aux` is 1 on a carry out of bit 3 (add) or a borrow into bit 3 (subtract).
- R5: After an update, `flag_parity` is 1 when result bits 7:0 contain an even number of ones, in both widths.
- R6: After an update, `flag_carry` is 1 on a carry out of the MSB (add) or a borrow into the MSB (subtract).
- R7: After an update, `flag_ovf` is 1 when the two's-complement result does not fit the selected width. For example, byte 73h + 4Fh gives C2h with overflow set and carry clear.
- R8: Add with carry and subtract with borrow include `carry_in`. Add and subtract ignore it.
- R9: Operations 4 to 7 write 0 to `flag_carry`, `flag_ovf` and `flag_aux`.
- R10: The flags load on a rising clock edge only while `flag_we` is 1; otherwise they hold.
- R11: While `rst_n` is low, all six flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| opa | input | 16 | First operand |
| opb | input | 16 | Second operand |
| carry_in | input | 1 | Incoming carry/borrow |
| op_sel | input | 3 | Operation code |
| word_mode | input | 1 | 1 = 16-bit, 0 = 8-bit |
| flag_we | input | 1 | Flag register write enable |
| result | output | 16 | Operation result |
| flag_sign | output | 1 | Sign flag |
| flag_zero | output | 1 | Zero flag |
| flag_aux | output | 1 | Auxiliary carry/borrow flag |
| flag_parity | output | 1 | Even parity of low byte |
| flag_carry | output | 1 | Carry/borrow flag |
| flag_ovf | output | 1 | Signed overflow flag |

## Verification
A fault in the datapath appears in `result` within the same cycle, before any clock edge. A fault in the flag logic appears one clock after a write-enabled operation. A flag register that loads without permission changes an output on the cycle after an operation with `flag_we` low, so every hold step is compared against the previously observed flags. Width-dependent faults are caught by pairing each operation with both byte and word mode, because carry and sign come from different bits in each width.

// File: rtl/sfu_pkg.sv
package sfu_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADC  = 3'd1,
    OP_SUB  = 3'd2,
    OP_SBB  = 3'd3,
    OP_AND  = 3'd4,
    OP_OR   = 3'd5,
    OP_XOR  = 3'd6,
    OP_PASS = 3'd7
  } sfu_op_e;

  typedef struct packed {
    logic s;
    logic z;
    logic a;
    logic p;
    logic c;
    logic o;
  } sfu_flags_t;
endpackage

// File: rtl/sfu_addsub.sv
module sfu_addsub #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  input  logic          sub,
  input  logic          word,
  output logic [DW-1:0] res,
  output logic          cout,
  output logic          aux,
  output logic          ovf
);
  localparam int BW = DW / 2;

  function automatic logic msb_of(input logic [DW-1:0] v, input logic w);
    return w ? v[DW-1] : v[BW-1];
  endfunction

  logic [DW-1:0] b_eff;
  logic          c0;
  logic [DW:0]   wsum;
  logic [BW:0]   bsum;
  logic [4:0]    nsum;
  logic          ma, mb, mr;

  assign b_eff = sub ? ~b : b;
  assign c0    = sub ? ~cin : cin;
  assign wsum  = {1'b0, a} + {1'b0, b_eff} + {{DW{1'b0}}, c0};
  assign bsum  = {1'b0, a[BW-1:0]} + {1'b0, b_eff[BW-1:0]} + {{BW{1'b0}}, c0};
  assign nsum  = {1'b0, a[3:0]} + {1'b0, b_eff[3:0]} + {4'b0, c0};

  assign res  = word ? wsum[DW-1:0] : {{BW{1'b0}}, bsum[BW-1:0]};
  assign cout = (word ? wsum[DW] : bsum[BW]) ^ sub;
  assign aux  = nsum[4] ^ sub;

  assign ma  = msb_of(a, word);
  assign mb  = msb_of(b_eff, word);
  assign mr  = msb_of(res, word);
  assign ovf = (ma == mb) && (mr != ma);
endmodule

// File: rtl/sfu_logic.sv
module sfu_logic #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [2:0]    op,
  input  logic          word,
  output logic [DW-1:0] res
);
  import sfu_pkg::*;
  localparam int BW = DW / 2;

  logic [DW-1:0] full;

  always_comb begin
    case (op)
      OP_AND:  full = a & b;
      OP_OR:   full = a | b;
      OP_XOR:  full = a ^ b;
      default: full = a;
    endcase
  end

  assign res = word ? full : {{BW{1'b0}}, full[BW-1:0]};
endmodule

// File: rtl/sfu_flaggen.sv
module sfu_flaggen #(
  parameter int DW = 16
) (
  input  logic [DW-1:0]       res,
  input  logic                word,
  input  logic                is_logic,
  input  logic                cout,
  input  logic                aux,
  input  logic                ovf,
  output sfu_pkg::sfu_flags_t nxt
);
  localparam int BW = DW / 2;

  function automatic logic even_ones(input logic [7:0] v);
    return ~^v;
  endfunction

  always_comb begin
    nxt.s = word ? res[DW-1] : res[BW-1];
    nxt.z = (res == '0);
    nxt.p = even_ones(res[7:0]);
    nxt.a = is_logic ? 1'b0 : aux;
    nxt.c = is_logic ? 1'b0 : cout;
    nxt.o = is_logic ? 1'b0 : ovf;
  end
endmodule

// File: rtl/status_flag_unit.sv
module status_flag_unit #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic          carry_in,
  input  logic [2:0]    op_sel,
  input  logic          word_mode,
  input  logic          flag_we,
  output logic [DW-1:0] result,
  output logic          flag_sign,
  output logic          flag_zero,
  output logic          flag_aux,
  output logic          flag_parity,
  output logic          flag_carry,
  output logic          flag_ovf
);
  import sfu_pkg::*;
  localparam int BW = DW / 2;

  logic          is_logic, is_sub, use_cin;
  logic [DW-1:0] arith_res, logic_res;
  logic          ar_cout, ar_aux, ar_ovf;
  sfu_flags_t    flag_nxt, flag_q;

  assign is_logic = op_sel[2];
  assign is_sub   = (op_sel == OP_SUB) || (op_sel == OP_SBB);
  assign use_cin  = (op_sel == OP_ADC) || (op_sel == OP_SBB);

  sfu_addsub #(.DW(DW)) u_addsub (
    .a(opa), .b(opb), .cin(use_cin & carry_in), .sub(is_sub), .word(word_mode),
    .res(arith_res), .cout(ar_cout), .aux(ar_aux), .ovf(ar_ovf)
  );

  sfu_logic #(.DW(DW)) u_logic (
    .a(opa), .b(opb), .op(op_sel), .word(word_mode), .res(logic_res)
  );

  assign result = is_logic ? logic_res : arith_res;

  sfu_flaggen #(.DW(DW)) u_flaggen (
    .res(result), .word(word_mode), .is_logic(is_logic),
    .cout(ar_cout), .aux(ar_aux), .ovf(ar_ovf), .nxt(flag_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= '0;
    else if (flag_we) flag_q <= flag_nxt;
  end

  assign flag_sign   = flag_q.s;
  assign flag_zero   = flag_q.z;
  assign flag_aux    = flag_q.a;
  assign flag_parity = flag_q.p;
  assign flag_carry  = flag_q.c;
  assign flag_ovf    = flag_q.o;

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |=> $stable(flag_q));

  p_logic_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && is_logic) |=> (!flag_carry && !flag_ovf && !flag_aux));

  p_sign_msb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |=> (flag_sign == $past(word_mode ? result[DW-1] : result[BW-1])));

  p_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |=> (flag_zero == ($past(result) == '0)));

  p_parity_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |=> (flag_parity == ($countones($past(result[7:0])) % 2 == 0)));

  p_byte_upper_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !word_mode |-> (result[DW-1:BW] == '0));
endmodule

// File: tb/sim_status_flag_unit.sv
module sim_status_flag_unit;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] opa = 0, opb = 0;
  logic        carry_in = 0;
  logic [2:0]  op_sel = 0;
  logic        word_mode = 0;
  logic        flag_we = 0;
  logic [15:0] result;
  logic        fs, fz, fa, fp, fc, fo;

  int checks = 0;
  int errors = 0;
  logic [5:0] last_flags;

  always #4 clk = ~clk;

  status_flag_unit u0 (
    .clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb), .carry_in(carry_in),
    .op_sel(op_sel), .word_mode(word_mode), .flag_we(flag_we), .result(result),
    .flag_sign(fs), .flag_zero(fz), .flag_aux(fa), .flag_parity(fp),
    .flag_carry(fc), .flag_ovf(fo)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  // returns {res[15:0], s, z, a, p, c, o}
  function automatic logic [21:0] model(input int op, input int a, input int b,
                                        input int cin, input bit word);
    int mask, half, ua, ub, ci, sa, sb, full, ss, r, ones;
    bit s, z, ax, p, c, o;
    mask = word ? 32'hFFFF : 32'hFF;
    half = mask / 2 + 1;
    ua = a & mask; ub = b & mask;
    ci = (op == 1 || op == 3) ? cin : 0;
    sa = (ua >= half) ? ua - (mask + 1) : ua;
    sb = (ub >= half) ? ub - (mask + 1) : ub;
    c = 0; ax = 0; o = 0;
    if (op <= 1) begin
      full = ua + ub + ci;
      r = full & mask; c = full > mask;
      ax = ((ua & 15) + (ub & 15) + ci) > 15;
      ss = sa + sb + ci; o = (ss >= half) || (ss < -half);
    end else if (op <= 3) begin
      full = ua - ub - ci;
      r = full & mask; c = full < 0;
      ax = ((ua & 15) - (ub & 15) - ci) < 0;
      ss = sa - sb - ci; o = (ss >= half) || (ss < -half);
    end else if (op == 4) r = ua & ub;
    else if (op == 5) r = ua | ub;
    else if (op == 6) r = ua ^ ub;
    else r = ua;
    s = (r & half) != 0;
    z = (r == 0);
    ones = 0;
    for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
    p = (ones % 2) == 0;
    return {r[15:0], s, z, ax, p, c, o};
  endfunction

  task automatic do_op(input int op, input int a, input int b, input int cin,
                       input bit word, input bit we);
    logic [21:0] e;
    @(negedge clk);
    op_sel = op[2:0]; opa = a[15:0]; opb = b[15:0];
    carry_in = cin[0]; word_mode = word; flag_we = we;
    e = model(op, a, b, cin, word);
    #1;
    chk(op == 1 || op == 3 ? "R1 R8 result" : "R1 result", result, e[21:6]);
    @(posedge clk);
    @(negedge clk);
    flag_we = 0;
    if (we) begin
      chk("R2 sign", fs, e[5]);
      chk("R3 zero", fz, e[4]);
      chk("R4 aux", fa, e[3]);
      chk("R5 parity", fp, e[2]);
      chk("R6 carry", fc, e[1]);
      chk("R7 ovf", fo, e[0]);
      if (op >= 4) chk("R9 logic clears", {fc, fo, fa}, 0);
    end else begin
      chk("R10 hold", {fs, fz, fa, fp, fc, fo}, last_flags);
    end
    last_flags = {fs, fz, fa, fp, fc, fo};
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk("R11 reset flags", {fs, fz, fa, fp, fc, fo}, 0);
    rst_n = 1;
    last_flags = 0;

    // directed corner cases
    do_op(0, 'h73, 'h4F, 0, 0, 1);        // R7: C2h, overflow, no carry
    chk("R7 C2h overflow", {fs, fc, fo}, 3'b101);
    do_op(0, 'hFFFF, 'h0001, 0, 1, 1);    // R3 R6: wraps to zero
    chk("R3 R6 word wrap", {fz, fc, fa, fp}, 4'b1111);
    do_op(2, 'h00, 'h01, 0, 0, 1);        // R6 R4: borrow
    chk("R4 R6 byte borrow", {fc, fa, fs}, 3'b111);
    do_op(0, 'h10, 'h20, 1, 0, 1);        // R8: plain add ignores carry_in
    chk("R8 add ignores cin", result, 'h30);
    do_op(1, 'h10, 'h20, 1, 0, 1);
    chk("R8 adc uses cin", result, 'h31);
    do_op(3, 'h8000, 'h0000, 1, 1, 1);    // R7: 8000h-1 overflows
    chk("R7 sbb word ovf", {fo, fs}, 2'b10);
    do_op(0, 'h0100, 'h0200, 0, 1, 1);    // R5: low byte zero, parity even
    chk("R5 low byte parity", {fp, fz}, 2'b10);
    do_op(0, 'h1234, 'hFF00, 0, 0, 1);    // R1: byte mode ignores upper
    chk("R1 byte upper zero", result, 'h34);
    do_op(2, 'h0005, 'h0003, 0, 1, 0);    // R10: no write
    do_op(5, 'hF0F0, 'h0F0F, 0, 1, 1);    // R9
    do_op(7, 'h0080, 'h1234, 0, 0, 1);    // R1 pass

    // random mix
    for (int n = 0; n < 400; n++) begin
      int op, a, b, cin;
      bit w, we;
      op = $urandom % 8;
      a = $urandom % 65536;
      b = $urandom % 65536;
      cin = $urandom % 2;
      w = ($urandom % 2) != 0;
      we = ($urandom % 4) != 0;
      do_op(op, a, b, cin, w, we);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule